// File: doc/BRIEF.md
# Memory Access Permission Checker

This block sits in front of a processor's load, store and instruction-fetch path and sorts each access into a fault class. Every cycle it may accept one request. A request carries an address, a size mask, an access kind and a privileged RAM-enable bit. A profile select picks one of two rule sets. One cycle later the block returns the corrected address, a misalignment flag and a single fault code. It raises, queues and prioritises no interrupts, and it touches no memory. The surrounding pipeline decides what to do with the reported class.

The strict profile traps misaligned accesses. It then clears the low address bits named by the mask and checks the address windows against that corrected address. The relaxed profile never reports misalignment. It always force-aligns instruction fetches, and it adds one error window that applies only to data accesses wider than a word. In both profiles a small RAM area near the bottom of the protected region is open only while the RAM-enable bit is set.

Top module: `mem_access_guard`

## Requirements
- R1: `rsp_valid` equals the `req_valid` of the previous cycle. A synchronous reset (`rst` high) forces `rsp_valid`, `rsp_misalign` and `rsp_fault` to 0.
- R2: Whenever `rsp_valid` is 0, `rsp_misalign` is 0 and `rsp_fault` is 0 (no fault).
- R3: Strict profile (`req_relaxed`=0). For kinds 0 (load), 1 (store) and 2 (fetch), `rsp_misalign` is 1 exactly when `req_addr & req_mask` is nonzero. `rsp_addr` is `req_addr` with the mask bits cleared. The mask is 0, 1, 3, 7 or 15 for 1, 2, 4, 8 or 16 bytes.
- R4: Strict profile. A load or store whose corrected address lies in 0xFE800000–0xFEFEFFFF or 0xFEFF0600–0xFEFF7FFF reports code 1 (load error) for a load and code 2 (store error) for a store.
- R5: Strict profile. A load or store in 0xFE000000–0xFE7FFFFF reports code 3 (data exception).
- R6: Strict profile. A fetch in either R4 window reports code 4 (fetch error). Otherwise a fetch in 0xFE004000–0xFE7FFFFF reports code 5 (fetch exception). Otherwise a fetch in 0xFE000000–0xFE003FFF reports code 5 only when `req_ram_en` is 0.
- R7: Relaxed profile (`req_relaxed`=1). `rsp_misalign` is always 0. A load or store returns `req_addr` unchanged. A fetch returns `req_addr` with the mask bits cleared.
- R8: Relaxed profile. A load or store in 0xFE800000–0xFEFEFFFF reports code 1 or 2 as in R4. When the mask is greater than 3, the same codes are also reported in 0xFEFF0000–0xFEFFFFFF.
- R9: Relaxed profile. A load or store in 0xFE000000–0xFE3FFFFF or 0xFE408000–0xFE7FFFFF reports code 3. In 0xFE400000–0xFE407FFF it reports code 3 only when `req_ram_en` is 0.
- R10: Relaxed profile. A fetch in 0xFE800000–0xFEFFFFFF reports code 4 and a fetch in 0xFE008000–0xFE7FFFFF reports code 5. In 0xFE000000–0xFE007FFF a fetch reports code 5 only when `req_ram_en` is 0.
- R11: Kind 3 is reserved. It reports code 0 and no misalignment, and it returns the address unchanged in both profiles.
- R12: A misalignment and a window fault on the same access are reported together: `rsp_misalign` is 1 and `rsp_fault` carries the window code. Any address outside every window reports code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Access address |
| req_mask | input | 4 | Size mask (0,1,3,7,15) |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| req_ram_en | input | 1 | Privileged RAM-enable bit |
| req_relaxed | input | 1 | 0 strict profile, 1 relaxed profile |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_addr | output | 32 | Corrected address |
| rsp_misalign | output | 1 | Strict-profile misalignment flag |
| rsp_fault | output | 3 | Fault code 0..5 |

## Verification
Every result of a request applied before rising edge N is due right after edge N. This covers the valid flag, the corrected address, the misalignment flag and the fault code, all of which pass through exactly one register stage. The bench drives each request on a falling edge and compares all four outputs on the next falling edge, half a cycle after the capturing edge. Idle cycles are checked the same way, one falling edge after the request valid drops. Reset is checked on a falling edge while reset is held.

// File: rtl/mag_pkg.sv
package mag_pkg;

  localparam int unsigned WIN_W = 32;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_LOAD_ERR  = 3'd1,
    FLT_STORE_ERR = 3'd2,
    FLT_DATA_EXC  = 3'd3,
    FLT_FETCH_ERR = 3'd4,
    FLT_FETCH_EXC = 3'd5
  } fault_e;

  // Protected region boundaries (inclusive)
  localparam logic [WIN_W-1:0] REG_BASE     = 32'hFE00_0000;
  localparam logic [WIN_W-1:0] LO_RAM_S_END = 32'hFE00_3FFF;
  localparam logic [WIN_W-1:0] LO_RAM_R_END = 32'hFE00_7FFF;
  localparam logic [WIN_W-1:0] MID_A_END    = 32'hFE3F_FFFF;
  localparam logic [WIN_W-1:0] MID_RAM_BASE = 32'hFE40_0000;
  localparam logic [WIN_W-1:0] MID_RAM_END  = 32'hFE40_7FFF;
  localparam logic [WIN_W-1:0] EXC_END      = 32'hFE7F_FFFF;
  localparam logic [WIN_W-1:0] ERR_BASE     = 32'hFE80_0000;
  localparam logic [WIN_W-1:0] ERR_END      = 32'hFEFE_FFFF;
  localparam logic [WIN_W-1:0] TOP_BASE     = 32'hFEFF_0000;
  localparam logic [WIN_W-1:0] TOP_HOLE_LO  = 32'hFEFF_0600;
  localparam logic [WIN_W-1:0] TOP_HOLE_HI  = 32'hFEFF_7FFF;
  localparam logic [WIN_W-1:0] TOP_END      = 32'hFEFF_FFFF;

endpackage

// File: rtl/mag_align.sv
module mag_align
  import mag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MASK_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [MASK_W-1:0] mask,
  input  logic [1:0]        kind,
  input  logic              relaxed,
  output logic [ADDR_W-1:0] fixed_addr,
  output logic              misalign
);

  localparam int PAD_W = ADDR_W - MASK_W;

  logic [ADDR_W-1:0] mask_ext;
  logic              low_hit;
  logic              checked;
  logic              clear_low;

  assign mask_ext = {{PAD_W{1'b0}}, mask};
  assign low_hit  = |(addr[MASK_W-1:0] & mask);
  assign checked  = (kind != KIND_RSVD);

  // Strict clears low bits for every checked kind, relaxed only for fetch
  assign clear_low = relaxed ? (kind == KIND_FETCH) : checked;

  always_comb begin
    fixed_addr = clear_low ? (addr & ~mask_ext) : addr;
    misalign   = !relaxed && checked && low_hit;
  end

  // R3: a flagged access always leaves with the low bits cleared
  always_comb begin
    if (misalign) begin
      a_r3_flag_implies_clear: assert ((fixed_addr & mask_ext) == '0);
    end
  end

endmodule

// File: rtl/mag_window.sv
module mag_window
  import mag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MASK_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [MASK_W-1:0] mask,
  input  logic [1:0]        kind,
  input  logic              ram_en,
  input  logic              relaxed,
  output logic [2:0]        fault
);

  localparam logic [MASK_W-1:0] WORD_MASK = MASK_W'(3);

  function automatic logic inw(input logic [ADDR_W-1:0] a,
                               input logic [WIN_W-1:0]  lo,
                               input logic [WIN_W-1:0]  hi);
    return (a >= ADDR_W'(lo)) && (a <= ADDR_W'(hi));
  endfunction

  logic is_fetch, is_data;
  logic err_hit, exc_hit;

  assign is_fetch = (kind == KIND_FETCH);
  assign is_data  = (kind == KIND_LOAD) || (kind == KIND_STORE);

  always_comb begin
    err_hit = 1'b0;
    exc_hit = 1'b0;
    if (!relaxed) begin
      err_hit = inw(addr, TOP_HOLE_LO, TOP_HOLE_HI) || inw(addr, ERR_BASE, ERR_END);
      if (is_fetch) begin
        exc_hit = inw(addr, LO_RAM_S_END + 1, EXC_END)
               || (!ram_en && inw(addr, REG_BASE, LO_RAM_S_END));
      end else begin
        exc_hit = inw(addr, REG_BASE, EXC_END);
      end
    end else begin
      if (is_fetch) begin
        err_hit = inw(addr, ERR_BASE, TOP_END);
        exc_hit = inw(addr, LO_RAM_R_END + 1, EXC_END)
               || (!ram_en && inw(addr, REG_BASE, LO_RAM_R_END));
      end else begin
        err_hit = inw(addr, ERR_BASE, ERR_END)
               || ((mask > WORD_MASK) && inw(addr, TOP_BASE, TOP_END));
        exc_hit = inw(addr, REG_BASE, MID_A_END)
               || inw(addr, MID_RAM_END + 1, EXC_END)
               || (!ram_en && inw(addr, MID_RAM_BASE, MID_RAM_END));
      end
    end
  end

  // Error classes win over exception classes
  always_comb begin
    fault = FLT_NONE;
    if (is_fetch) begin
      if (err_hit)      fault = FLT_FETCH_ERR;
      else if (exc_hit) fault = FLT_FETCH_EXC;
    end else if (is_data) begin
      if (err_hit)      fault = (kind == KIND_STORE) ? FLT_STORE_ERR : FLT_LOAD_ERR;
      else if (exc_hit) fault = FLT_DATA_EXC;
    end
  end

  // R6: fetch classes only ever come from fetch accesses
  always_comb begin
    if (fault == FLT_FETCH_ERR || fault == FLT_FETCH_EXC) begin
      a_r6_fetch_class_kind: assert (kind == KIND_FETCH);
    end
  end

  // R11: reserved kind never yields a class
  always_comb begin
    if (kind == KIND_RSVD) begin
      a_r11_rsvd_clean: assert (fault == FLT_NONE);
    end
  end

endmodule

// File: rtl/mag_resp_reg.sv
module mag_resp_reg #(
  parameter int ADDR_W  = 32,
  parameter int FAULT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [ADDR_W-1:0]  in_addr,
  input  logic               in_misalign,
  input  logic [FAULT_W-1:0] in_fault,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  out_addr,
  output logic               out_misalign,
  output logic [FAULT_W-1:0] out_fault
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_addr     <= '0;
      out_misalign <= 1'b0;
      out_fault    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_addr     <= in_addr;
        out_misalign <= in_misalign;
        out_fault    <= in_fault;
      end else begin
        out_misalign <= 1'b0;
        out_fault    <= '0;
      end
    end
  end

  // R2: idle response carries no fault
  a_r2_idle_clean: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_misalign && out_fault == '0));

endmodule

// File: rtl/mem_access_guard.sv
module mem_access_guard
  import mag_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int MASK_W  = 4,
  parameter int FAULT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [MASK_W-1:0]  req_mask,
  input  logic [1:0]         req_kind,
  input  logic               req_ram_en,
  input  logic               req_relaxed,
  output logic               rsp_valid,
  output logic [ADDR_W-1:0]  rsp_addr,
  output logic               rsp_misalign,
  output logic [FAULT_W-1:0] rsp_fault
);

  localparam int PAD_W = ADDR_W - MASK_W;

  logic [ADDR_W-1:0]  fixed_addr;
  logic               misalign;
  logic [2:0]         win_fault;

  mag_align #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_align (
    .addr       (req_addr),
    .mask       (req_mask),
    .kind       (req_kind),
    .relaxed    (req_relaxed),
    .fixed_addr (fixed_addr),
    .misalign   (misalign)
  );

  // Windows are judged on the corrected address
  mag_window #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_window (
    .addr    (fixed_addr),
    .mask    (req_mask),
    .kind    (req_kind),
    .ram_en  (req_ram_en),
    .relaxed (req_relaxed),
    .fault   (win_fault)
  );

  mag_resp_reg #(.ADDR_W(ADDR_W), .FAULT_W(FAULT_W)) u_resp (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (req_valid),
    .in_addr      (fixed_addr),
    .in_misalign  (misalign),
    .in_fault     (FAULT_W'(win_fault)),
    .out_valid    (rsp_valid),
    .out_addr     (rsp_addr),
    .out_misalign (rsp_misalign),
    .out_fault    (rsp_fault)
  );

  // R1: valid follows request by one cycle
  a_r1_valid_rise: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r1_valid_fall: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R7: relaxed requests never flag misalignment
  a_r7_relaxed_no_misalign: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_relaxed) |=> !rsp_misalign);

  // R7/R3: fetch addresses leave aligned in both profiles
  a_r7_fetch_aligned: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == KIND_FETCH) |=>
      ((rsp_addr & {{PAD_W{1'b0}}, $past(req_mask)}) == '0));

  // R11: reserved kind passes the address through untouched
  a_r11_rsvd_passthru: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == KIND_RSVD) |=> (rsp_addr == $past(req_addr)));

endmodule

// File: tb/sim_mem_access_guard.sv
`timescale 1ns/1ps
module sim_mem_access_guard;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_mask = '0;
  logic [1:0]  req_kind = '0;
  logic        req_ram_en = 1'b0;
  logic        req_relaxed = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic        rsp_misalign;
  logic [2:0]  rsp_fault;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  mem_access_guard u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_mask(req_mask), .req_kind(req_kind), .req_ram_en(req_ram_en),
    .req_relaxed(req_relaxed), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_misalign(rsp_misalign), .rsp_fault(rsp_fault)
  );

  function automatic logic btw(input logic [31:0] x, input logic [31:0] lo,
                               input logic [31:0] hi);
    return (x >= lo) && (x <= hi);
  endfunction

  // Reference from the requirements: returns {misalign, code, address}
  function automatic logic [35:0] model(input logic [31:0] a, input logic [3:0] m,
                                        input logic [1:0] k, input logic ram,
                                        input logic rel);
    logic [31:0] c;
    logic        mis;
    logic [2:0]  code;
    logic        e, x;
    c = a; mis = 1'b0; code = 3'd0; e = 1'b0; x = 1'b0;
    if (k == 2'd3) return {1'b0, 3'd0, a};
    if (!rel) begin
      mis = (a[3:0] & m) != 4'd0;
      c = {a[31:4], a[3:0] & ~m};
      e = btw(c, 32'hFE800000, 32'hFEFEFFFF) || btw(c, 32'hFEFF0600, 32'hFEFF7FFF);
      if (k == 2'd2)
        x = btw(c, 32'hFE004000, 32'hFE7FFFFF) || (!ram && btw(c, 32'hFE000000, 32'hFE003FFF));
      else
        x = btw(c, 32'hFE000000, 32'hFE7FFFFF);
    end else if (k == 2'd2) begin
      c = {a[31:4], a[3:0] & ~m};
      e = btw(c, 32'hFE800000, 32'hFEFFFFFF);
      x = btw(c, 32'hFE008000, 32'hFE7FFFFF) || (!ram && btw(c, 32'hFE000000, 32'hFE007FFF));
    end else begin
      e = btw(c, 32'hFE800000, 32'hFEFEFFFF) || (m > 4'd3 && btw(c, 32'hFEFF0000, 32'hFEFFFFFF));
      x = btw(c, 32'hFE000000, 32'hFE3FFFFF) || btw(c, 32'hFE408000, 32'hFE7FFFFF)
        || (!ram && btw(c, 32'hFE400000, 32'hFE407FFF));
    end
    if (k == 2'd2)      code = e ? 3'd4 : (x ? 3'd5 : 3'd0);
    else if (e)         code = (k == 2'd1) ? 3'd2 : 3'd1;
    else if (x)         code = 3'd3;
    return {mis, code, c};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive on a falling edge, compare on the next falling edge
  task automatic access(input logic [31:0] a, input logic [3:0] m, input logic [1:0] k,
                        input logic ram, input logic rel, input string tag);
    logic [35:0] exp;
    exp = model(a, m, k, ram, rel);
    req_valid = 1'b1; req_addr = a; req_mask = m; req_kind = k;
    req_ram_en = ram; req_relaxed = rel;
    @(negedge clk);
    chk("R1", "valid", {31'd0, rsp_valid}, 32'd1);
    chk(tag, "addr", rsp_addr, exp[31:0]);
    chk(tag, "misalign", {31'd0, rsp_misalign}, {31'd0, exp[35]});
    chk(tag, "fault", {29'd0, rsp_fault}, {29'd0, exp[34:32]});
  endtask

  task automatic idle();
    req_valid = 1'b0;
    req_addr = $urandom; req_kind = 2'd1; req_mask = 4'd15;
    @(negedge clk);
    chk("R1", "idle valid", {31'd0, rsp_valid}, 32'd0);
    chk("R2", "idle misalign", {31'd0, rsp_misalign}, 32'd0);
    chk("R2", "idle fault", {29'd0, rsp_fault}, 32'd0);
  endtask

  function automatic string tag_of(input logic [1:0] k, input logic rel);
    if (k == 2'd3) return "R11";
    if (!rel) return (k == 2'd2) ? "R6" : "R4";
    return (k == 2'd2) ? "R10" : "R8";
  endfunction

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] bounds [14];
    logic [3:0]  masks [5];
    logic [31:0] a;
    int          seed;
    bounds = '{32'hFE000000, 32'hFE003FFF, 32'hFE004000, 32'hFE007FFF, 32'hFE008000,
               32'hFE3FFFFF, 32'hFE400000, 32'hFE407FFF, 32'hFE408000, 32'hFE7FFFFF,
               32'hFE800000, 32'hFEFEFFFF, 32'hFEFF0600, 32'hFEFF8000};
    masks = '{4'd0, 4'd1, 4'd3, 4'd7, 4'd15};
    seed = $urandom(32'd20515);

    // R1: reset state, request valid held high during reset
    req_valid = 1'b1; req_addr = 32'hFE800001; req_mask = 4'd1; req_kind = 2'd1;
    repeat (3) @(negedge clk);
    chk("R1", "reset valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1", "reset misalign", {31'd0, rsp_misalign}, 32'd0);
    chk("R1", "reset fault", {29'd0, rsp_fault}, 32'd0);
    rst = 1'b0;
    idle();

    // R3: strict misalignment, all three kinds
    access(32'h0000_1003, 4'd3, 2'd0, 1'b1, 1'b0, "R3");
    access(32'h0000_2006, 4'd7, 2'd1, 1'b1, 1'b0, "R3");
    access(32'h0000_300A, 4'd3, 2'd2, 1'b1, 1'b0, "R3");
    access(32'h0000_4008, 4'd7, 2'd0, 1'b1, 1'b0, "R3");
    // R4: strict data errors, load code 1 and store code 2
    access(32'hFEFF0600, 4'd3, 2'd0, 1'b1, 1'b0, "R4");
    access(32'hFEFEFFFC, 4'd3, 2'd1, 1'b1, 1'b0, "R4");
    access(32'hFEFF8000, 4'd0, 2'd0, 1'b1, 1'b0, "R4");
    // R5: strict data exception code 3
    access(32'hFE000000, 4'd0, 2'd1, 1'b1, 1'b0, "R5");
    access(32'hFE7FFFF8, 4'd7, 2'd0, 1'b0, 1'b0, "R5");
    // R6: strict fetch windows and RAM gate
    access(32'hFE900000, 4'd3, 2'd2, 1'b1, 1'b0, "R6");
    access(32'hFE004000, 4'd3, 2'd2, 1'b1, 1'b0, "R6");
    access(32'hFE003FFC, 4'd3, 2'd2, 1'b1, 1'b0, "R6");
    access(32'hFE003FFC, 4'd3, 2'd2, 1'b0, 1'b0, "R6");
    // R7: relaxed, no flag, data passes through, fetch aligned
    access(32'h0000_1003, 4'd3, 2'd0, 1'b1, 1'b1, "R7");
    access(32'h0000_200F, 4'd15, 2'd2, 1'b1, 1'b1, "R7");
    // R8: relaxed size-dependent top window
    access(32'hFEFF0010, 4'd3, 2'd0, 1'b1, 1'b1, "R8");
    access(32'hFEFF0010, 4'd7, 2'd0, 1'b1, 1'b1, "R8");
    access(32'hFEFF0010, 4'd15, 2'd1, 1'b1, 1'b1, "R8");
    access(32'hFE800000, 4'd0, 2'd1, 1'b1, 1'b1, "R8");
    // R9: relaxed data exception and RAM gate
    access(32'hFE404000, 4'd3, 2'd0, 1'b1, 1'b1, "R9");
    access(32'hFE404000, 4'd3, 2'd0, 1'b0, 1'b1, "R9");
    access(32'hFE408000, 4'd3, 2'd1, 1'b1, 1'b1, "R9");
    access(32'hFE3FFFFF, 4'd0, 2'd1, 1'b1, 1'b1, "R9");
    // R10: relaxed fetch windows
    access(32'hFEFFFFFE, 4'd3, 2'd2, 1'b1, 1'b1, "R10");
    access(32'hFE008002, 4'd3, 2'd2, 1'b1, 1'b1, "R10");
    access(32'hFE004000, 4'd3, 2'd2, 1'b1, 1'b1, "R10");
    access(32'hFE004000, 4'd3, 2'd2, 1'b0, 1'b1, "R10");
    // R11: reserved kind
    access(32'hFE800003, 4'd3, 2'd3, 1'b0, 1'b0, "R11");
    access(32'hFEFF0011, 4'd15, 2'd3, 1'b0, 1'b1, "R11");
    // R12: flag plus window code together, and a clean address
    access(32'hFE800001, 4'd1, 2'd1, 1'b1, 1'b0, "R12");
    access(32'hFE000006, 4'd3, 2'd2, 1'b0, 1'b0, "R12");
    access(32'h1234_5670, 4'd15, 2'd0, 1'b0, 1'b0, "R12");
    idle();

    // Random mix
    for (int i = 0; i < 2500; i++) begin
      int sel;
      logic [1:0] k;
      logic rel;
      sel = $urandom % 8;
      if (sel < 5)       a = {8'hFE, 24'($urandom)};
      else if (sel < 7)  a = bounds[$urandom % 14] + 32'($urandom % 16) - 32'd8;
      else               a = $urandom;
      k   = 2'($urandom);
      rel = 1'($urandom);
      if ($urandom % 10 == 0) idle();
      access(a, masks[$urandom % 5], k, 1'($urandom), rel, tag_of(k, rel));
    end
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule